// File: doc/BRIEF.md
# Serial FPGA configuration shifter

This block configures a programmable device through that device's one-bit serial configuration port. A start command begins a load. The block raises the device's program request. It then waits for the init line to fall, which shows that the device is clearing its configuration memory. It keeps program raised for a fixed settling period, releases it, and waits for init to rise again, which shows that the device is ready for data. Each wait has its own timeout.

The bitstream arrives as bytes over a valid/ready handshake. The number of bytes is latched with the start command. Each byte is sent most significant bit first on a clock that the block generates itself. For every bit the clock is driven low, the data line then changes, and the clock then rises. Each of these phases lasts a fixed number of system cycles. When the last byte has been sent, the data line is held high and the clock keeps toggling until the device raises done, or until the done timeout expires.

The result is reported as a one-cycle status pulse with a pass/fail flag. Readback cannot be done through this port, so a readback request is refused with a failure status straight away.

Top module: `serial_cfg_loader`

## Requirements
- R1: After reset, `prog_o`=0, `cfg_clk_o`=0, `cfg_dat_o`=1, `byte_ready_o`=0 and `status_valid_o`=0.
- R2: A start command in idle raises `prog_o` (1 = program requested). After `init_i` is seen low, `prog_o` stays high for `PROG_CYC` more cycles and then drops. If `init_i` is not seen low within `INIT_TMO_CYC` cycles, the load fails and no clock edge is produced.
- R3: After program is released, no configuration clock edge and no byte request occurs until `init_i` is seen high. If `init_i` does not rise within `INIT_TMO_CYC` cycles, the load fails.
- R4: Each byte is sent as 8 bits, most significant bit first. A bit is valid at the rising edge of `cfg_clk_o`.
- R5: Each bit spends `STEP_CYC` cycles with the clock low before the data changes, `STEP_CYC` cycles low after the change, and exactly `STEP_CYC` cycles high. The data line never changes while the clock is high.
- R6: `byte_ready_o` is high only while the clock is low and program is released, and only after all 8 bits of the previous byte have been clocked. Exactly `byte_count_i` bytes are taken.
- R7: After the last byte, `cfg_dat_o` is held at 1 and the clock toggles, with a done check before each low phase, until `done_i` is seen. The load then passes.
- R8: If `done_i` is not seen within `DONE_TMO_CYC` cycles after the data ends, the load fails.
- R9: A readback request in idle gives a failure status on the next cycle and produces no program or clock activity.
- R10: A byte count of zero sends no data bits and goes straight to done polling.
- R11: Every load ends in exactly one `status_valid_o` pulse of one cycle, with `status_ok_o` = 1 for pass and 0 for fail.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin a load (used in idle only) |
| readback_i | input | 1 | Readback request (always refused) |
| byte_count_i | input | BYTES_W | Number of bitstream bytes, latched at start |
| byte_i | input | SHIFT_W | Bitstream byte |
| byte_valid_i | input | 1 | Byte is present |
| byte_ready_o | output | 1 | Block takes the byte this cycle when valid |
| init_i | input | 1 | Device init line level |
| done_i | input | 1 | Device done line level |
| prog_o | output | 1 | Program request to the device, 1 = asserted |
| cfg_clk_o | output | 1 | Generated configuration clock |
| cfg_dat_o | output | 1 | Serial configuration data |
| status_valid_o | output | 1 | One-cycle end-of-operation pulse |
| status_ok_o | output | 1 | 1 = pass, 0 = fail, valid with the pulse |

## Verification
The bench builds the block with `STEP_CYC`=2, `PROG_CYC`=3, `INIT_TMO_CYC`=20 and `DONE_TMO_CYC`=60. These values shrink the millisecond-scale waits to a few dozen cycles, so that each of the three timeouts can be made to expire within a short run. They also keep the clock phases long enough to measure. A behavioural device model drives init and done with programmable delays, or holds them stuck. The bench records every rising clock edge in a queue and compares the captured bits against the expected MSB-first stream and the all-ones tail, including the case where the byte source stalls between bytes.

// File: rtl/cfg_ld_pkg.sv
// Package: shared state encoding for the serial configuration shifter.
// Assumes: nothing outside this package depends on the numeric codes.
package cfg_ld_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PROG_ON,
        ST_PROG_HOLD,
        ST_WAIT_READY,
        ST_FETCH,
        ST_BIT_LO,
        ST_BIT_DAT,
        ST_BIT_HI,
        ST_TAIL_CHK,
        ST_TAIL_LO,
        ST_TAIL_HI,
        ST_REPORT
    } ld_state_e;

    // Larger of two integers, used when sizing shared counters.
    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/cfg_ld_countdown.sv
// Module: loadable down-counter that stops at zero.
// Does: load_i writes value_i; otherwise the count falls by one each cycle
//       until it reaches zero, where it stays. zero_o flags the zero count.
// Assumes: value_i fits in W bits. The count resets to zero (expired).
module cfg_ld_countdown #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] value_i,
    output logic         zero_o
);

    logic [W-1:0] cnt_q;

    // Count register: load, or decrement while not yet zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= value_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero_o = (cnt_q == '0);

    // R8: once expired, the counter stays expired until it is reloaded.
    assert_zero_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (zero_o && !load_i) |=> zero_o);

endmodule

// File: rtl/cfg_ld_shifter.sv
// Module: byte-to-bit shifter, MSB first.
// Does: load_i captures a byte, shift_i moves to the next lower bit,
//       last_o marks the final bit of the byte.
// Assumes: shift_i is not raised on the last bit; a new load starts the next byte.
module cfg_ld_shifter #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [WIDTH-1:0] byte_i,
    input  logic             shift_i,
    output logic             bit_o,
    output logic             last_o
);

    localparam int IDX_W = (WIDTH > 1) ? $clog2(WIDTH) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WIDTH - 1);

    logic [WIDTH-1:0] sr_q;
    logic [IDX_W-1:0] idx_q;

    // Shift register and bit position.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q  <= '0;
            idx_q <= '0;
        end else if (load_i) begin
            sr_q  <= byte_i;
            idx_q <= '0;
        end else if (shift_i) begin
            sr_q  <= {sr_q[WIDTH-2:0], 1'b0};
            idx_q <= idx_q + 1'b1;
        end
    end

    assign bit_o  = sr_q[WIDTH-1];
    assign last_o = (idx_q == LAST_IDX);

    // R4: the first bit presented after a load is the byte's top bit.
    assert_msb_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (bit_o == $past(byte_i[WIDTH-1])));

endmodule

// File: rtl/serial_cfg_loader.sv
// Module: serial configuration shifter for a programmable device.
// Does: program/init handshake, MSB-first bit clocking of a byte stream,
//       a done-polling tail with data held high, and a pass/fail pulse.
// Assumes: init_i and done_i are already synchronised to clk; STEP_CYC and
//          PROG_CYC are at least 1. Readback is refused with a failure status.
module serial_cfg_loader #(
    parameter int BYTES_W      = 16,
    parameter int SHIFT_W      = 8,
    parameter int STEP_CYC     = 4,
    parameter int PROG_CYC     = 50,
    parameter int INIT_TMO_CYC = 100000,
    parameter int DONE_TMO_CYC = 1000000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic               readback_i,
    input  logic [BYTES_W-1:0] byte_count_i,
    input  logic [SHIFT_W-1:0] byte_i,
    input  logic               byte_valid_i,
    output logic               byte_ready_o,
    input  logic               init_i,
    input  logic               done_i,
    output logic               prog_o,
    output logic               cfg_clk_o,
    output logic               cfg_dat_o,
    output logic               status_valid_o,
    output logic               status_ok_o
);
    import cfg_ld_pkg::*;

    localparam int DLY_MAX = imax(STEP_CYC, PROG_CYC);
    localparam int TMO_MAX = imax(INIT_TMO_CYC, DONE_TMO_CYC);
    localparam int DLY_W   = $clog2(DLY_MAX + 1);
    localparam int TMO_W   = $clog2(TMO_MAX + 1);
    localparam logic [DLY_W-1:0] STEP_LD = DLY_W'(STEP_CYC - 1);
    localparam logic [DLY_W-1:0] PROG_LD = DLY_W'(PROG_CYC - 1);
    localparam logic [TMO_W-1:0] INIT_LD = TMO_W'(INIT_TMO_CYC);
    localparam logic [TMO_W-1:0] DONE_LD = TMO_W'(DONE_TMO_CYC);

    ld_state_e          state_q, state_d;
    logic [BYTES_W-1:0] rem_q;
    logic               ok_q, ok_d;
    logic               dat_q;
    logic               dly_ld, dly_zero;
    logic [DLY_W-1:0]   dly_val;
    logic               tmo_ld, tmo_zero;
    logic [TMO_W-1:0]   tmo_val;
    logic               sh_load, sh_shift, sh_bit, sh_last;
    logic               rem_load, rem_dec, rem_zero;
    logic               dat_from_sh, dat_to_one;

    // Phase timer: length of each clock phase and of the program hold.
    cfg_ld_countdown #(.W(DLY_W)) u_phase (
        .clk(clk), .rst_n(rst_n), .load_i(dly_ld), .value_i(dly_val), .zero_o(dly_zero)
    );

    // Timeout timer: reloaded on entry to each wait.
    cfg_ld_countdown #(.W(TMO_W)) u_tmo (
        .clk(clk), .rst_n(rst_n), .load_i(tmo_ld), .value_i(tmo_val), .zero_o(tmo_zero)
    );

    // Byte shifter feeding the data pin.
    cfg_ld_shifter #(.WIDTH(SHIFT_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .load_i(sh_load), .byte_i(byte_i),
        .shift_i(sh_shift), .bit_o(sh_bit), .last_o(sh_last)
    );

    assign rem_zero = (rem_q == '0);

    // Sequencer: next state and the one-cycle controls for timers and shifter.
    always_comb begin
        state_d     = state_q;
        ok_d        = ok_q;
        dly_ld      = 1'b0;
        dly_val     = STEP_LD;
        tmo_ld      = 1'b0;
        tmo_val     = INIT_LD;
        sh_load     = 1'b0;
        sh_shift    = 1'b0;
        rem_load    = 1'b0;
        rem_dec     = 1'b0;
        dat_from_sh = 1'b0;
        dat_to_one  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (readback_i) begin
                    state_d = ST_REPORT;
                    ok_d    = 1'b0;
                end else if (start_i) begin
                    state_d  = ST_PROG_ON;
                    tmo_ld   = 1'b1;
                    rem_load = 1'b1;
                end
            end
            ST_PROG_ON: begin
                if (!init_i) begin
                    state_d = ST_PROG_HOLD;
                    dly_ld  = 1'b1;
                    dly_val = PROG_LD;
                end else if (tmo_zero) begin
                    state_d = ST_REPORT;
                    ok_d    = 1'b0;
                end
            end
            ST_PROG_HOLD: begin
                if (dly_zero) begin
                    state_d = ST_WAIT_READY;
                    tmo_ld  = 1'b1;
                end
            end
            ST_WAIT_READY: begin
                if (init_i) begin
                    if (rem_zero) begin
                        state_d    = ST_TAIL_CHK;
                        tmo_ld     = 1'b1;
                        tmo_val    = DONE_LD;
                        dat_to_one = 1'b1;
                    end else begin
                        state_d = ST_FETCH;
                    end
                end else if (tmo_zero) begin
                    state_d = ST_REPORT;
                    ok_d    = 1'b0;
                end
            end
            ST_FETCH: begin
                if (byte_valid_i) begin
                    state_d = ST_BIT_LO;
                    sh_load = 1'b1;
                    rem_dec = 1'b1;
                    dly_ld  = 1'b1;
                end
            end
            ST_BIT_LO: begin
                if (dly_zero) begin
                    state_d     = ST_BIT_DAT;
                    dly_ld      = 1'b1;
                    dat_from_sh = 1'b1;
                end
            end
            ST_BIT_DAT: begin
                if (dly_zero) begin
                    state_d = ST_BIT_HI;
                    dly_ld  = 1'b1;
                end
            end
            ST_BIT_HI: begin
                if (dly_zero) begin
                    if (!sh_last) begin
                        state_d  = ST_BIT_LO;
                        sh_shift = 1'b1;
                        dly_ld   = 1'b1;
                    end else if (rem_zero) begin
                        state_d    = ST_TAIL_CHK;
                        tmo_ld     = 1'b1;
                        tmo_val    = DONE_LD;
                        dat_to_one = 1'b1;
                    end else begin
                        state_d = ST_FETCH;
                    end
                end
            end
            ST_TAIL_CHK: begin
                if (done_i) begin
                    state_d = ST_REPORT;
                    ok_d    = 1'b1;
                end else if (tmo_zero) begin
                    state_d = ST_REPORT;
                    ok_d    = 1'b0;
                end else begin
                    state_d = ST_TAIL_LO;
                    dly_ld  = 1'b1;
                end
            end
            ST_TAIL_LO: begin
                if (tmo_zero) begin
                    state_d = ST_REPORT;
                    ok_d    = 1'b0;
                end else if (dly_zero) begin
                    state_d = ST_TAIL_HI;
                    dly_ld  = 1'b1;
                end
            end
            ST_TAIL_HI: begin
                if (tmo_zero) begin
                    state_d = ST_REPORT;
                    ok_d    = 1'b0;
                end else if (dly_zero) begin
                    state_d = ST_TAIL_CHK;
                end
            end
            ST_REPORT: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State, verdict, remaining-byte count and data-pin registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ok_q    <= 1'b0;
            rem_q   <= '0;
            dat_q   <= 1'b1;
        end else begin
            state_q <= state_d;
            ok_q    <= ok_d;
            if (rem_load) begin
                rem_q <= byte_count_i;
            end else if (rem_dec) begin
                rem_q <= rem_q - 1'b1;
            end
            if (dat_to_one) begin
                dat_q <= 1'b1;
            end else if (dat_from_sh) begin
                dat_q <= sh_bit;
            end
        end
    end

    // Pin decode from the state register.
    assign prog_o         = (state_q == ST_PROG_ON) || (state_q == ST_PROG_HOLD);
    assign cfg_clk_o      = (state_q == ST_BIT_HI) || (state_q == ST_TAIL_HI);
    assign cfg_dat_o      = dat_q;
    assign byte_ready_o   = (state_q == ST_FETCH);
    assign status_valid_o = (state_q == ST_REPORT);
    assign status_ok_o    = (state_q == ST_REPORT) && ok_q;

    // R6: bytes are requested only with the clock low and program released.
    assert_ready_clk_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        byte_ready_o |-> (!cfg_clk_o && !prog_o));

    // R5: data pin is stable for the whole high phase of the clock.
    assert_dat_stable_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_clk_o && $past(cfg_clk_o)) |-> $stable(cfg_dat_o));

    // R7: the data pin stays high throughout done polling.
    assert_tail_dat_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q inside {ST_TAIL_CHK, ST_TAIL_LO, ST_TAIL_HI}) |-> cfg_dat_o);

    // R9: a readback request in idle is refused on the next cycle.
    assert_readback_reject_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && readback_i) |=> (status_valid_o && !status_ok_o && !prog_o));

    // R11: the status pulse lasts a single cycle.
    assert_status_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        status_valid_o |=> !status_valid_o);

endmodule

// File: tb/sim_serial_cfg_loader.sv
// Bench: behavioural device model, byte source and edge monitor, all sampled
// on the falling clock edge; expected bits are held in queues.
module sim_serial_cfg_loader;

    localparam int STEP  = 2;
    localparam int PROGC = 3;
    localparam int ITMO  = 20;
    localparam int DTMO  = 60;
    localparam int BW    = 8;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst_n = 1'b0;
    logic          start_i = 1'b0, readback_i = 1'b0;
    logic [BW-1:0] byte_count_i = '0;
    logic [7:0]    byte_i = '0;
    logic          byte_valid_i = 1'b0, byte_ready_o;
    logic          init_r = 1'b1, done_r = 1'b0;
    logic          prog_o, cfg_clk_o, cfg_dat_o, status_valid_o, status_ok_o;

    serial_cfg_loader #(
        .BYTES_W(BW), .SHIFT_W(8), .STEP_CYC(STEP), .PROG_CYC(PROGC),
        .INIT_TMO_CYC(ITMO), .DONE_TMO_CYC(DTMO)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .readback_i(readback_i),
        .byte_count_i(byte_count_i), .byte_i(byte_i), .byte_valid_i(byte_valid_i),
        .byte_ready_o(byte_ready_o), .init_i(init_r), .done_i(done_r),
        .prog_o(prog_o), .cfg_clk_o(cfg_clk_o), .cfg_dat_o(cfg_dat_o),
        .status_valid_o(status_valid_o), .status_ok_o(status_ok_o)
    );

    int checks = 0, fails = 0, cyc = 0;

    // Test configuration and reference state.
    logic [7:0] src_q[$];
    bit         exp_q[$];
    bit         cap_q[$];
    int  nbytes = 0, gap = 0, done_edges = 0, lo_dly = 2, hi_dly = 4;
    bit  mute_lo = 0, mute_hi = 0, mute_done = 0;
    int  gap_cnt = 0, consumed = 0, tail_edges = 0;
    int  stable_viol = 0, width_viol = 0, ready_viol = 0, hi_len = 0;
    int  cnt_lo = 0, cnt_hi = 0, prog_after_lo = 0, stat_seen = 0;
    bit  stat_ok = 0, prev_clk = 0, prev_dat = 1, prev_valid = 0, prev_ready = 0;

    task automatic check(input bit cond, input string req, input int act, input int exp);
        checks++;
        if (!cond) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Per-cycle model: byte source, edge monitor and device init/done behaviour.
    always @(negedge clk) begin
        cyc++;
        if (prev_valid && prev_ready) begin
            void'(src_q.pop_front());
            consumed++;
            gap_cnt = gap;
        end else if (gap_cnt > 0) begin
            gap_cnt--;
        end
        byte_valid_i = (src_q.size() > 0) && (gap_cnt == 0);
        byte_i       = (src_q.size() > 0) ? src_q[0] : 8'h00;
        prev_valid   = byte_valid_i;
        prev_ready   = byte_ready_o;

        if (cfg_clk_o && !prev_clk) begin
            cap_q.push_back(cfg_dat_o);
            hi_len = 1;
        end else if (cfg_clk_o) begin
            hi_len++;
            if (cfg_dat_o != prev_dat) stable_viol++;
        end
        if (!cfg_clk_o && prev_clk && hi_len != STEP) width_viol++;
        if (byte_ready_o && (cfg_clk_o || prog_o || (cap_q.size() % 8) != 0)) ready_viol++;

        if (prog_o) begin
            cnt_hi = 0;
            if (init_r) begin
                cnt_lo++;
                if (!mute_lo && cnt_lo >= lo_dly) init_r = 1'b0;
            end else begin
                prog_after_lo++;
            end
        end else if (!init_r) begin
            cnt_lo = 0;
            cnt_hi++;
            if (!mute_hi && cnt_hi >= hi_dly) init_r = 1'b1;
        end
        tail_edges = (cap_q.size() > 8 * nbytes) ? cap_q.size() - 8 * nbytes : 0;
        done_r = !mute_done && !prog_o && init_r && (cap_q.size() >= 8 * nbytes)
                 && (tail_edges >= done_edges);

        if (status_valid_o) begin
            stat_seen++;
            stat_ok = status_ok_o;
        end
        prev_clk = cfg_clk_o;
        prev_dat = cfg_dat_o;
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic setup(input int n, input int g, input int de,
                         input bit mlo, input bit mhi, input bit mdn, input int seed);
        @(posedge clk); #1;
        src_q.delete(); exp_q.delete(); cap_q.delete();
        nbytes = n; gap = g; done_edges = de;
        mute_lo = mlo; mute_hi = mhi; mute_done = mdn;
        consumed = 0; stable_viol = 0; width_viol = 0; ready_viol = 0;
        prog_after_lo = 0; stat_seen = 0; stat_ok = 0; gap_cnt = 0;
        for (int i = 0; i < n; i++) begin
            logic [7:0] b;
            b = (seed == 0) ? ((i == 0) ? 8'hA5 : (i == 1) ? 8'h80 : 8'h01)
                            : 8'((i * 37 + seed) ^ 8'h5A);
            src_q.push_back(b);
            for (int k = 7; k >= 0; k--) exp_q.push_back(b[k]);
        end
        byte_count_i = BW'(n);
    endtask

    task automatic run_start(output int lat);
        start_i = 1'b1;
        @(posedge clk); #1;
        start_i = 1'b0;
        lat = 0;
        while (stat_seen == 0 && lat < 5000) begin
            @(negedge clk); #1;
            lat++;
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic check_load(input string tag, input bit exp_ok);
        int mism;
        mism = 0;
        check(stat_seen == 1, {tag, " R11 one status pulse"}, stat_seen, 1);
        check(stat_ok == exp_ok, {tag, " R7 status_ok"}, stat_ok, exp_ok);
        check(cap_q.size() >= exp_q.size(), {tag, " R4 bit count"}, cap_q.size(), exp_q.size());
        for (int i = 0; i < exp_q.size() && i < cap_q.size(); i++)
            if (cap_q[i] != exp_q[i]) mism++;
        check(mism == 0, {tag, " R4 MSB-first bit mismatches"}, mism, 0);
        mism = 0;
        for (int i = exp_q.size(); i < cap_q.size(); i++)
            if (cap_q[i] != 1'b1) mism++;
        check(mism == 0, {tag, " R7 tail data low"}, mism, 0);
        check(stable_viol == 0, {tag, " R5 data change while clock high"}, stable_viol, 0);
        check(width_viol == 0, {tag, " R5 high phase width"}, width_viol, 0);
        check(ready_viol == 0, {tag, " R6 ready mid-byte"}, ready_viol, 0);
        check(consumed == nbytes, {tag, " R6 bytes taken"}, consumed, nbytes);
        check(prog_after_lo >= PROGC && prog_after_lo <= PROGC + 1,
              {tag, " R2 program hold after init low"}, prog_after_lo, PROGC);
    endtask

    initial begin
        int lat;
        repeat (3) @(negedge clk);
        // R1: reset state.
        check(prog_o == 0 && cfg_clk_o == 0, "R1 reset prog/clk", {prog_o, cfg_clk_o}, 0);
        check(cfg_dat_o == 1, "R1 reset data pin", cfg_dat_o, 1);
        check(byte_ready_o == 0 && status_valid_o == 0, "R1 reset ready/status",
              {byte_ready_o, status_valid_o}, 0);
        @(posedge clk); #1 rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R4 R7: three bytes with edge patterns, done after three tail edges.
        setup(3, 0, 3, 0, 0, 0, 0);
        run_start(lat);
        check_load("A", 1'b1);
        check(cap_q.size() - 24 == 3, "A R7 tail edges", cap_q.size() - 24, 3);

        // R6: five bytes with a stalling source, done after one tail edge.
        setup(5, 4, 1, 0, 0, 0, 7);
        run_start(lat);
        check_load("B", 1'b1);
        check(cap_q.size() - 40 == 1, "B R7 tail edges", cap_q.size() - 40, 1);

        // R10: zero bytes, device already done.
        setup(0, 0, 0, 0, 0, 0, 1);
        run_start(lat);
        check_load("C", 1'b1);
        check(cap_q.size() == 0, "C R10 no clock edges", cap_q.size(), 0);

        // R2: init never falls.
        setup(2, 0, 1, 1, 0, 0, 3);
        run_start(lat);
        check(stat_seen == 1 && stat_ok == 0, "D R2 init-low timeout fails", stat_ok, 0);
        check(lat >= ITMO - 2 && lat <= ITMO + 6, "D R2 timeout latency", lat, ITMO);
        check(cap_q.size() == 0 && prog_o == 0, "D R2 no clock, program dropped",
              cap_q.size(), 0);

        // R3: init never rises after release.
        setup(2, 0, 1, 0, 1, 0, 4);
        run_start(lat);
        check(stat_seen == 1 && stat_ok == 0, "E R3 init-high timeout fails", stat_ok, 0);
        check(cap_q.size() == 0 && consumed == 0, "E R3 no data before ready",
              cap_q.size(), 0);
        @(posedge clk); #1 mute_hi = 0;
        repeat (8) @(negedge clk);

        // R8: done never appears.
        setup(1, 0, 1, 0, 0, 1, 9);
        run_start(lat);
        check(stat_seen == 1 && stat_ok == 0, "F R8 done timeout fails", stat_ok, 0);
        check(cap_q.size() - 8 >= 11 && cap_q.size() - 8 <= 13, "F R8 tail edge count",
              cap_q.size() - 8, 12);

        // R9: readback request refused at once.
        @(posedge clk); #1;
        stat_seen = 0;
        readback_i = 1'b1;
        @(posedge clk); #1;
        readback_i = 1'b0;
        check(status_valid_o == 1 && status_ok_o == 0, "G R9 readback refused next cycle",
              {status_valid_o, status_ok_o}, 2);
        check(prog_o == 0 && cfg_clk_o == 0, "G R9 no pin activity", {prog_o, cfg_clk_o}, 0);
        @(posedge clk); #1;
        check(status_valid_o == 0, "G R11 pulse ends", status_valid_o, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule